// File: doc/BRIEF.md
# CAN Error Frame Generator

This block drives the error signalling sequence of a CAN node once one of the node's error detectors has fired. A one-cycle error pulse arms it. The bit currently on the wire is allowed to finish, and the node then forces the bus dominant for six bit times as its error flag. Other nodes may pile their own flags on top of it, so the bus can stay dominant for up to twelve bits. The block drives recessive, waits for the first recessive sample, and counts the eight recessive bits of the delimiter. A dominant sample part-way through the delimiter restarts that count.

Bit timing comes from a sample strobe that pulses for one clock cycle at the sample point of every bit. The receive line is looked at only on that strobe. The transmit output is an override meant to be combined with the normal transmit path. A done pulse closes each error frame.

While an error frame is running, the block also watches for a bus held dominant for longer than any legal overlap of error flags allows. When it sees one, it raises a sticky fault flag, which software clears through a dedicated input.

Top module: `can_errframe_gen`

## Requirements
- R1: After reset, tx_level is 1 (recessive), and frame_active, frame_done and stuck_dom are all 0.
- R2: An err_pulse while frame_active is 0 raises frame_active on the next cycle. tx_level stays recessive until the next bit_strobe, so the bit in progress is completed.
- R3: Starting the cycle after that bit_strobe, tx_level is 0 (dominant) for exactly 6 bit_strobes and then returns to 1. tx_level is never 0 while frame_active is 0.
- R4: After its flag, the node keeps tx_level at 1 and waits while the bus reads dominant (rx_level 0). A total dominant field of 6 to 12 sampled bits ends the frame normally and leaves stuck_dom at 0.
- R5: The first recessive sample (rx_level 1) after the flag is delimiter bit 1. The frame ends on the 8th consecutive recessive sample, so a frame with no overlap ends 14 strobes after the flag starts.
- R6: A dominant sample during the delimiter count discards the recessive bits counted so far and restarts the wait for recessive.
- R7: frame_done is high for exactly one cycle: the cycle after the strobe of the 8th delimiter bit. frame_active falls in that same cycle.
- R8: While a frame is active, the 13th consecutive dominant sample, counted from the first flag bit, sets stuck_dom on the following cycle.
- R9: stuck_dom stays set until stuck_clr is asserted. If a new stuck detection and stuck_clr fall in the same cycle, the detection wins.
- R10: An err_pulse while frame_active is 1 is ignored, and the frame's timing is unchanged.
- R11: rx_level is ignored in cycles where bit_strobe is 0. A dominant glitch between strobes does not restart the delimiter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse at each bit's sample point |
| rx_level | input | 1 | Received bus level, 1 recessive, 0 dominant |
| err_pulse | input | 1 | Error detected by any checker |
| stuck_clr | input | 1 | Clears the stuck-at-dominant flag |
| tx_level | output | 1 | Transmit override, 0 forces dominant |
| frame_active | output | 1 | Error frame in progress |
| frame_done | output | 1 | One-cycle pulse at error frame end |
| stuck_dom | output | 1 | Sticky bus stuck-at-dominant flag |

## Verification
Two functions can fall in the same cycle: a fresh stuck-at-dominant detection and the software clear of the sticky flag. The bench provokes this by holding the bus dominant for many bits and asserting stuck_clr on the strobe cycle of a bit that is itself still dominant. It then expects stuck_dom to stay set, because the detection wins. Later it clears the flag on a strobe after the bus has recovered and expects the flag to drop. Random stimulus also lands err_pulse in the cycle of frame_done. In that cycle the block is already idle, so the pulse must start a fresh frame, and the reference model checks this cycle by cycle.

// File: rtl/can_ef_pkg.sv
package can_ef_pkg;

  typedef enum logic [2:0] {
    EF_IDLE  = 3'd0,
    EF_ARM   = 3'd1,
    EF_FLAG  = 3'd2,
    EF_WAIT  = 3'd3,
    EF_DELIM = 3'd4
  } ef_state_t;

  localparam logic BUS_DOM = 1'b0;
  localparam logic BUS_REC = 1'b1;

  // Width of a counter that must hold the values 0..n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // States in which the bus is sampled for the dominant run.
  function automatic logic watches_bus(input ef_state_t s);
    return (s == EF_FLAG) || (s == EF_WAIT) || (s == EF_DELIM);
  endfunction

endpackage

// File: rtl/ef_bit_counter.sv
module ef_bit_counter #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = W'(LIMIT);

  // Saturating counter, clear has priority over step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (step && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/ef_stuck_flag.sv
module ef_stuck_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hit,
  input  logic clr_req,
  output logic flag
);

  // Sticky flag: a detection in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_hit) begin
      flag <= 1'b1;
    end else if (clr_req) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/ef_seq.sv
module ef_seq
  import can_ef_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  logic      rx_dom,
  input  logic      err_pulse,
  input  logic      flag_last,
  input  logic      delim_last,
  output ef_state_t state,
  output logic      flag_start,
  output logic      flag_end,
  output logic      delim_step,
  output logic      delim_restart,
  output logic      frame_end
);

  ef_state_t nxt;

  // Events, each valid only in the cycle of the strobe that causes it.
  always_comb begin
    flag_start    = (state == EF_ARM) && strobe;
    flag_end      = (state == EF_FLAG) && strobe && flag_last;
    delim_step    = strobe && !rx_dom &&
                    ((state == EF_WAIT) || (state == EF_DELIM));
    delim_restart = strobe && rx_dom && (state == EF_DELIM);
    frame_end     = (state == EF_DELIM) && strobe && !rx_dom && delim_last;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      EF_IDLE:  if (err_pulse)  nxt = EF_ARM;
      EF_ARM:   if (flag_start) nxt = EF_FLAG;
      EF_FLAG:  if (flag_end)   nxt = EF_WAIT;
      EF_WAIT:  if (delim_step) nxt = EF_DELIM;
      EF_DELIM: begin
        if (delim_restart)  nxt = EF_WAIT;
        else if (frame_end) nxt = EF_IDLE;
      end
      default:  nxt = EF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= EF_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/can_errframe_gen.sv
module can_errframe_gen
  import can_ef_pkg::*;
#(
  parameter int unsigned FLAG_BITS  = 6,
  parameter int unsigned DELIM_BITS = 8,
  parameter int unsigned MAX_DOM    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_strobe,
  input  logic rx_level,
  input  logic err_pulse,
  input  logic stuck_clr,
  output logic tx_level,
  output logic frame_active,
  output logic frame_done,
  output logic stuck_dom
);

  localparam int unsigned FW = cnt_bits(FLAG_BITS);
  localparam int unsigned DW = cnt_bits(DELIM_BITS);
  localparam int unsigned MW = cnt_bits(MAX_DOM);

  localparam logic [FW-1:0] FLAG_LAST  = FW'(FLAG_BITS - 1);
  localparam logic [DW-1:0] DELIM_LAST = DW'(DELIM_BITS - 1);
  localparam logic [MW-1:0] DOM_LIMIT  = MW'(MAX_DOM);

  ef_state_t      state;
  logic           rx_dom;
  logic           flag_start, flag_end, delim_step, delim_restart, frame_end;
  logic           flag_last, delim_last;
  logic [FW-1:0]  flag_cnt;
  logic [DW-1:0]  delim_cnt;
  logic [MW-1:0]  dom_cnt;
  logic           dom_step, dom_clear, stuck_hit;
  logic           done_q;

  assign rx_dom = (rx_level == BUS_DOM);

  ef_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (bit_strobe),
    .rx_dom        (rx_dom),
    .err_pulse     (err_pulse),
    .flag_last     (flag_last),
    .delim_last    (delim_last),
    .state         (state),
    .flag_start    (flag_start),
    .flag_end      (flag_end),
    .delim_step    (delim_step),
    .delim_restart (delim_restart),
    .frame_end     (frame_end)
  );

  // Bits of the own error flag.
  ef_bit_counter #(.LIMIT(FLAG_BITS), .W(FW)) u_flag_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flag_start),
    .step  (bit_strobe && (state == EF_FLAG)),
    .count (flag_cnt)
  );
  assign flag_last = (flag_cnt == FLAG_LAST);

  // Consecutive recessive delimiter bits.
  ef_bit_counter #(.LIMIT(DELIM_BITS), .W(DW)) u_delim_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flag_end || delim_restart),
    .step  (delim_step),
    .count (delim_cnt)
  );
  assign delim_last = (delim_cnt == DELIM_LAST);

  // Dominant run on the bus since the flag began.
  assign dom_step  = bit_strobe && rx_dom && watches_bus(state);
  assign dom_clear = flag_start || (bit_strobe && !rx_dom);

  ef_bit_counter #(.LIMIT(MAX_DOM), .W(MW)) u_dom_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (dom_clear),
    .step  (dom_step),
    .count (dom_cnt)
  );
  assign stuck_hit = dom_step && (dom_cnt == DOM_LIMIT);

  ef_stuck_flag u_stuck (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_hit (stuck_hit),
    .clr_req (stuck_clr),
    .flag    (stuck_dom)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= frame_end;
  end

  assign tx_level     = (state == EF_FLAG) ? BUS_DOM : BUS_REC;
  assign frame_active = (state != EF_IDLE);
  assign frame_done   = done_q;

endmodule

// File: rtl/can_errframe_chk.sv
module can_errframe_chk #(
  parameter int unsigned DW = 4,
  parameter int unsigned MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_strobe,
  input logic          rx_level,
  input logic          err_pulse,
  input logic          stuck_clr,
  input logic          tx_level,
  input logic          frame_active,
  input logic          frame_done,
  input logic          stuck_dom,
  input logic          stuck_hit,
  input logic          delim_restart,
  input logic [DW-1:0] delim_cnt,
  input logic [MW-1:0] dom_cnt
);

  // R2
  err_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && err_pulse) |=> frame_active);

  // R3
  flag_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_level |-> frame_active);

  // R3
  flag_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_level) |-> $past(bit_strobe));

  // R5
  done_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(bit_strobe) && $past(rx_level)));

  // R6
  delim_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delim_restart |=> (delim_cnt == '0));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!frame_active && $past(frame_active)));

  // R8
  stuck_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_hit |=> stuck_dom);

  // R9
  stuck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_dom && !stuck_clr) |=> stuck_dom);

  // R10
  err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && err_pulse && !bit_strobe) |=> $stable(tx_level));

  // R11
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> ($stable(dom_cnt) && $stable(delim_cnt)));

endmodule

bind can_errframe_gen can_errframe_chk #(.DW(DW), .MW(MW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_strobe    (bit_strobe),
  .rx_level      (rx_level),
  .err_pulse     (err_pulse),
  .stuck_clr     (stuck_clr),
  .tx_level      (tx_level),
  .frame_active  (frame_active),
  .frame_done    (frame_done),
  .stuck_dom     (stuck_dom),
  .stuck_hit     (stuck_hit),
  .delim_restart (delim_restart),
  .delim_cnt     (delim_cnt),
  .dom_cnt       (dom_cnt)
);

// File: tb/can_errframe_gen_test.sv
`timescale 1ns/100ps
module can_errframe_gen_test;

  localparam int BITLEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_strobe = 1'b0;
  logic err_pulse = 1'b0;
  logic stuck_clr = 1'b0;
  logic other_dom = 1'b0;
  logic bus_stuck = 1'b0;
  wire  rx_level;
  wire  tx_level, frame_active, frame_done, stuck_dom;

  // Wired-AND bus: any node driving dominant pulls the line low.
  assign rx_level = tx_level & ~other_dom & ~bus_stuck;

  always #2 clk = ~clk;

  can_errframe_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_strobe   (bit_strobe),
    .rx_level     (rx_level),
    .err_pulse    (err_pulse),
    .stuck_clr    (stuck_clr),
    .tx_level     (tx_level),
    .frame_active (frame_active),
    .frame_done   (frame_done),
    .stuck_dom    (stuck_dom)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // Reference model state
  int m_ph = 0;   // 0 idle, 1 armed, 2 flag, 3 wait, 4 delimiter
  int m_fl = 0, m_dr = 0, m_rc = 0;
  bit m_done = 0, m_stuck = 0;
  bit s_stb, s_rx, s_err, s_clr;

  int cur_bit = 0;
  int done_at = -1;
  int n_dom_tx = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_hit();
    return s_stb && !s_rx && (m_ph >= 2) && (m_dr >= 12);
  endfunction

  task automatic model_step();
    bit hit;
    hit = model_hit();
    m_done = 0;
    case (m_ph)
      0: if (s_err) m_ph = 1;
      1: if (s_stb) begin m_ph = 2; m_fl = 0; m_dr = 0; end
      2: if (s_stb) begin
           m_dr = s_rx ? 0 : m_dr + 1;
           m_fl++;
           if (m_fl == 6) m_ph = 3;
         end
      3: if (s_stb) begin
           if (!s_rx) m_dr++;
           else begin m_dr = 0; m_rc = 1; m_ph = 4; end
         end
      4: if (s_stb) begin
           if (!s_rx) begin m_dr++; m_rc = 0; m_ph = 3; end
           else begin
             m_dr = 0; m_rc++;
             if (m_rc == 8) begin m_ph = 0; m_done = 1; end
           end
         end
      default: m_ph = 0;
    endcase
    if (s_stb && s_rx && m_ph < 2) m_dr = 0;
    m_stuck = hit ? 1'b1 : (s_clr ? 1'b0 : m_stuck);
  endtask

  task automatic compare();
    chk(tx_level == (m_ph != 2), "R3", "tx_level", tx_level, (m_ph != 2));
    chk(frame_active == (m_ph != 0), "R2", "frame_active", frame_active, (m_ph != 0));
    chk(frame_done == m_done, "R7", "frame_done", frame_done, m_done);
    chk(stuck_dom == m_stuck, "R8", "stuck_dom", stuck_dom, m_stuck);
  endtask

  task automatic tick(input bit stb, input bit oth, input bit err, input bit clr);
    @(negedge clk);
    bit_strobe = stb; other_dom = oth; err_pulse = err; stuck_clr = clr;
    #1;
    s_stb = stb; s_rx = rx_level; s_err = err; s_clr = clr;
    if (stb && !tx_level) n_dom_tx++;
    @(posedge clk);
    model_step();
    #1;
    compare();
    if (frame_done && done_at < 0) done_at = cur_bit;
  endtask

  task automatic one_bit(input bit oth, input bit err_first, input bit clr_strobe,
                         input bit glitch);
    for (int c = 0; c < BITLEN; c++)
      tick(c == BITLEN - 1, glitch ? (c == 1) : oth,
           err_first && (c == 0), clr_strobe && (c == BITLEN - 1));
    cur_bit++;
  endtask

  // Runs one error frame; the err bit is bit 0, its strobe starts the flag.
  task automatic run_frame(input int ext, input int dip, input int err_again,
                           input bit glitch, input int exp_done, input bit exp_stuck,
                           input string req);
    cur_bit = 0; done_at = -1; n_dom_tx = 0;
    tick(0, 0, 1, 0);
    chk(frame_active == 1, "R2", "active after err", frame_active, 1);
    chk(tx_level == 1, "R2", "tx before strobe", tx_level, 1);
    for (int c = 1; c < BITLEN; c++) tick(c == BITLEN - 1, 0, 0, 0);
    cur_bit++;
    for (int i = 1; i < 40 && done_at < 0; i++) begin
      bit oth;
      oth = (i <= 6 + ext) || (dip > 0 && i == 6 + ext + dip);
      one_bit(oth, i == err_again, 0, glitch && (i > 6 + ext));
    end
    chk(done_at == exp_done, req, "frame length in bits", done_at, exp_done);
    chk(n_dom_tx == 6, "R3", "dominant flag bits", n_dom_tx, 6);
    chk(stuck_dom == exp_stuck, exp_stuck ? "R8" : "R4", "stuck flag", stuck_dom, exp_stuck);
    chk(frame_active == 0, "R7", "active after done", frame_active, 0);
    one_bit(0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset values
    chk(tx_level == 1, "R1", "tx_level", tx_level, 1);
    chk(frame_active == 0, "R1", "frame_active", frame_active, 0);
    chk(frame_done == 0, "R1", "frame_done", frame_done, 0);
    chk(stuck_dom == 0, "R1", "stuck_dom", stuck_dom, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) one_bit(0, 0, 0, 0);

    run_frame(0, 0, 0, 0, 14, 0, "R5");   // R5 plain frame
    run_frame(3, 0, 0, 0, 17, 0, "R4");   // R4 overlap of 9 dominant bits
    run_frame(6, 0, 0, 0, 20, 0, "R4");   // R4 overlap of 12 dominant bits
    run_frame(0, 3, 0, 0, 17, 0, "R6");   // R6 dominant in delimiter
    run_frame(0, 0, 3, 0, 14, 0, "R10");  // R10 second err ignored
    run_frame(0, 0, 9, 0, 14, 0, "R10");  // R10 err during delimiter
    run_frame(0, 0, 0, 1, 14, 0, "R11");  // R11 glitches between strobes
    run_frame(7, 0, 0, 0, 21, 1, "R8");   // R8 13 dominant bits

    one_bit(0, 0, 1, 0);
    chk(stuck_dom == 0, "R9", "stuck after clear", stuck_dom, 0);

    // R9 detection and clear in the same cycle: detection wins
    bus_stuck = 1'b1;
    one_bit(0, 1, 0, 0);
    for (int i = 0; i < 16; i++) one_bit(0, 0, 0, 0);
    chk(stuck_dom == 1, "R8", "stuck on held bus", stuck_dom, 1);
    one_bit(0, 0, 1, 0);
    chk(stuck_dom == 1, "R9", "set wins over clear", stuck_dom, 1);
    one_bit(0, 0, 0, 0);
    chk(stuck_dom == 1, "R9", "sticky", stuck_dom, 1);
    bus_stuck = 1'b0;
    for (int i = 0; i < 10; i++) one_bit(0, 0, 0, 0);
    chk(frame_active == 0, "R5", "frame ends after release", frame_active, 0);
    one_bit(0, 0, 1, 0);
    chk(stuck_dom == 0, "R9", "cleared", stuck_dom, 0);

    // Random traffic against the reference model
    for (int b = 0; b < 400; b++) begin
      bit oth, er, cl, gl;
      oth = ($urandom % 4) == 0;
      er  = ($urandom % 6) == 0;
      cl  = ($urandom % 12) == 0;
      gl  = ($urandom % 10) == 0;
      for (int c = 0; c < BITLEN; c++)
        tick(c == BITLEN - 1, gl ? (c == 1) : oth,
             er && (c == ($urandom % BITLEN)), cl && (c == BITLEN - 1));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule